// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is the operational core of a small datapath. Two operand words, a 4-bit operation code and a carry input go in. One registered result word comes out, with a carry flag and a signed overflow flag. The upper two code bits choose where the result comes from: an adder, a bitwise logic stage, or a one-place shifter in either direction. The lower two code bits choose the function inside the arithmetic or logic group.

All arithmetic comes from one ripple adder that computes A + Y + carry_in. The adder's second operand Y is B, the inverse of B, all zeros or all ones, so add, add-with-carry, subtract, subtract-with-borrow, transfer, increment and decrement all come from the same hardware. Each result bit is picked by a 4:1 selector among the four candidate sources.

Two serial inputs fill the bit that a shift vacates. The outputs are loaded on a rising clock edge while the enable is high, and they hold otherwise.

Top module: `alsu_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `carry_out` and `overflow` are all cleared to 0 after that edge.
- R2: With `en` low at a rising edge, `result`, `carry_out` and `overflow` keep their previous values, whatever the other inputs do.
- R3: When op[3:2] = 00, result = (A + Y + carry_in) mod 2^W and carry_out is bit W of that sum. Y is chosen by op[1:0]: 00 = B, 01 = bitwise inverse of B, 10 = all zeros, 11 = all ones.
- R4: In the arithmetic group, op[1:0] = 10 with carry_in = 0 and op[1:0] = 11 with carry_in = 1 both return A unchanged. The first gives carry_out 0; the second gives carry_out 1.
- R5: In the arithmetic group, overflow equals the carry into bit W-1 XOR the carry out of bit W-1. This is 1 exactly when the two's-complement sum of A, Y and carry_in falls outside the signed W-bit range.
- R6: When op[3:2] = 01, each result bit is chosen by op[1:0]: 00 = A AND B, 01 = A OR B, 10 = A XOR B, 11 = NOT A.
- R7: When op[3:2] = 10, result bit i takes A bit i+1, and bit W-1 takes `ser_hi_in`.
- R8: When op[3:2] = 11, result bit i takes A bit i-1, and bit 0 takes `ser_lo_in`.
- R9: When op[3:2] is not 00, carry_out and overflow are loaded as 0.
- R10: An operation presented with `en` high appears on the outputs right after the next rising edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Load enable for the output registers |
| op | input | 4 | Operation code: [3:2] result source, [1:0] function |
| carry_in | input | 1 | Carry into the adder's least significant bit |
| a | input | W | First operand, and the word that is shifted |
| b | input | W | Second operand |
| ser_hi_in | input | 1 | Bit fed into the MSB on a right shift |
| ser_lo_in | input | 1 | Bit fed into the LSB on a left shift |
| result | output | W | Registered result word |
| carry_out | output | 1 | Registered adder carry (arithmetic group only) |
| overflow | output | 1 | Registered signed overflow (arithmetic group only) |

## Verification
The bench sweeps every A, B, code and carry input of a 4-bit instance. Each result is compared against sums and signed ranges computed from integers.

Several corner cases are targeted directly:
- **Carry out of the top bit.** Wrapping sums such as 15 + 15 + 1 and decrementing 0 would expose a design that loses or inverts the top carry.
- **Sign boundaries.** Operands such as 7 + 1 and -8 + (-1) would expose overflow taken from the wrong carry pair.
- **Shift end bits.** The vacated bit would expose a right and left serial fill that were swapped or dropped.
- **Non-arithmetic codes.** These would expose flags that leak out of the logic and shift groups.

Further directed steps catch a load that ignores the enable, or that shows up a cycle early.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    // Result source, taken from op[3:2]
    typedef enum logic [1:0] {
        SRC_ARITH = 2'b00,
        SRC_LOGIC = 2'b01,
        SRC_SHR   = 2'b10,
        SRC_SHL   = 2'b11
    } src_sel_e;

    // Adder second-operand choice, taken from op[1:0] in the arithmetic group
    typedef enum logic [1:0] {
        YSEL_B    = 2'b00,
        YSEL_NB   = 2'b01,
        YSEL_ZERO = 2'b10,
        YSEL_ONES = 2'b11
    } y_sel_e;

    // Bitwise function, taken from op[1:0] in the logic group
    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

    typedef struct packed {
        src_sel_e   src;
        logic [1:0] fn;
    } opcode_t;

    typedef struct packed {
        logic carry;
        logic ovf;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{carry: 1'b0, ovf: 1'b0};

    function automatic opcode_t split_op(input logic [3:0] op);
        opcode_t o;
        o.src = src_sel_e'(op[3:2]);
        o.fn  = op[1:0];
        return o;
    endfunction

    // One bit of the adder's Y operand
    function automatic logic pick_operand(input logic b_bit, input logic [1:0] fn);
        logic y;
        case (y_sel_e'(fn))
            YSEL_B:    y = b_bit;
            YSEL_NB:   y = ~b_bit;
            YSEL_ZERO: y = 1'b0;
            default:   y = 1'b1;
        endcase
        return y;
    endfunction

    // One bit of the logic stage
    function automatic logic logic_bit(input logic a_bit, input logic b_bit,
                                       input logic [1:0] fn);
        logic r;
        case (lop_e'(fn))
            LOP_AND: r = a_bit & b_bit;
            LOP_OR:  r = a_bit | b_bit;
            LOP_XOR: r = a_bit ^ b_bit;
            default: r = ~a_bit;
        endcase
        return r;
    endfunction

    // Full adder: returns {carry, sum}
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic c);
        logic s;
        logic co;
        s  = x ^ y ^ c;
        co = (x & y) | ((x ^ y) & c);
        return {co, s};
    endfunction

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    import alsu_pkg::*;

    logic [W:0]   carry;
    logic [W-1:0] y_op;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign y_op[i] = pick_operand(b[i], fn);
        assign {carry[i+1], sum[i]} = full_add(a[i], y_op[i], carry[i]);
    end

    assign cout = carry[W];
    assign ovf  = carry[W] ^ carry[W-1];

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    import alsu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = logic_bit(a[i], b[i], fn);
    end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         fill_hi,
    input  logic         fill_lo,
    output logic [W-1:0] shr,
    output logic [W-1:0] shl
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_top
            assign shr[i] = fill_hi;
        end else begin : g_mid_r
            assign shr[i] = a[i+1];
        end
        if (i == 0) begin : g_bot
            assign shl[i] = fill_lo;
        end else begin : g_mid_l
            assign shl[i] = a[i-1];
        end
    end

endmodule

// File: rtl/alsu_mux.sv
module alsu_mux #(
    parameter int W = 8
) (
    input  alsu_pkg::src_sel_e src,
    input  logic [W-1:0]       d_arith,
    input  logic [W-1:0]       d_logic,
    input  logic [W-1:0]       d_shr,
    input  logic [W-1:0]       d_shl,
    output logic [W-1:0]       y
);
    import alsu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (src)
                SRC_ARITH: y[i] = d_arith[i];
                SRC_LOGIC: y[i] = d_logic[i];
                SRC_SHR:   y[i] = d_shr[i];
                default:   y[i] = d_shl[i];
            endcase
        end
    end

endmodule

// File: rtl/alsu_unit.sv
module alsu_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [3:0]   op,
    input  logic         carry_in,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ser_hi_in,
    input  logic         ser_lo_in,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow
);
    import alsu_pkg::*;

    opcode_t      dec;
    logic [W-1:0] arith_d, logic_d, shr_d, shl_d, mux_d;
    logic         add_cout, add_ovf;
    flags_t       flags_d, flags_q;
    logic [W-1:0] result_q;

    assign dec = split_op(op);

    alsu_arith #(.W(W)) u_arith (
        .a(a), .b(b), .fn(dec.fn), .cin(carry_in),
        .sum(arith_d), .cout(add_cout), .ovf(add_ovf)
    );

    alsu_logic #(.W(W)) u_logic (
        .a(a), .b(b), .fn(dec.fn), .y(logic_d)
    );

    alsu_shift #(.W(W)) u_shift (
        .a(a), .fill_hi(ser_hi_in), .fill_lo(ser_lo_in),
        .shr(shr_d), .shl(shl_d)
    );

    alsu_mux #(.W(W)) u_mux (
        .src(dec.src), .d_arith(arith_d), .d_logic(logic_d),
        .d_shr(shr_d), .d_shl(shl_d), .y(mux_d)
    );

    always_comb begin
        flags_d = FLAGS_CLEAR;
        if (dec.src == SRC_ARITH) begin
            flags_d.carry = add_cout;
            flags_d.ovf   = add_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= FLAGS_CLEAR;
        end else if (en) begin
            result_q <= mux_d;
            flags_q  <= flags_d;
        end
    end

    assign result    = result_q;
    assign carry_out = flags_q.carry;
    assign overflow  = flags_q.ovf;

endmodule

// File: rtl/alsu_unit_chk.sv
module alsu_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [3:0]   op,
    input logic         carry_in,
    input logic [W-1:0] a,
    input logic         ser_hi_in,
    input logic         ser_lo_in,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         overflow
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result == '0 && !carry_out && !overflow));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(result) && $stable(carry_out) && $stable(overflow)));

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
        (en && op == 4'b0011 && carry_in) |=> (result == $past(a) && carry_out));

    assert_transfer_R4: assert property (@(posedge clk) disable iff (rst)
        (en && op == 4'b0010 && !carry_in) |=> (result == $past(a) && !carry_out && !overflow));

    assert_flags_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (en && op[3:2] != 2'b00) |=> (!carry_out && !overflow));

    assert_shift_right_R7: assert property (@(posedge clk) disable iff (rst)
        (en && op[3:2] == 2'b10) |=> (result == {$past(ser_hi_in), $past(a[W-1:1])}));

    assert_shift_left_R8: assert property (@(posedge clk) disable iff (rst)
        (en && op[3:2] == 2'b11) |=> (result == {$past(a[W-2:0]), $past(ser_lo_in)}));

endmodule

bind alsu_unit alsu_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .op(op), .carry_in(carry_in), .a(a),
    .ser_hi_in(ser_hi_in), .ser_lo_in(ser_lo_in),
    .result(result), .carry_out(carry_out), .overflow(overflow)
);

// File: tb/tb_alsu_unit.sv
`timescale 1ns/1ps
module tb_alsu_unit;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [3:0]   op = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         ser_hi_in = 1'b0;
    logic         ser_lo_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         overflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alsu_unit #(.W(W)) dut (
        .clk(clk), .rst(rst), .en(en), .op(op), .carry_in(carry_in),
        .a(a), .b(b), .ser_hi_in(ser_hi_in), .ser_lo_in(ser_lo_in),
        .result(result), .carry_out(carry_out), .overflow(overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v >= M / 2) ? v - M : v;
    endfunction

    // Apply one operation with en high and check it after the loading edge
    task automatic run_vec(input int av, input int bv, input int opv, input int cv);
        int src, fn, y, tot, st, exp_r, exp_c, exp_v;
        string tag;
        src = opv >> 2;
        fn  = opv & 3;
        a = W'(av); b = W'(bv); op = 4'(opv); carry_in = cv[0];
        ser_hi_in = cv[0];
        ser_lo_in = ~cv[0];
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exp_c = 0; exp_v = 0;
        case (src)
            0: begin
                y = (fn == 0) ? bv : (fn == 1) ? (~bv & (M - 1)) : (fn == 2) ? 0 : M - 1;
                tot = av + y + cv;
                exp_r = tot % M;
                exp_c = tot / M;
                st = sgn(av) + sgn(y) + cv;
                exp_v = (st > M / 2 - 1 || st < -(M / 2)) ? 1 : 0;
                tag = ((fn == 3 && cv == 1) || (fn == 2 && cv == 0)) ? "R4" : "R3";
            end
            1: begin
                exp_r = (fn == 0) ? (av & bv) : (fn == 1) ? (av | bv) :
                        (fn == 2) ? (av ^ bv) : (~av & (M - 1));
                tag = "R6";
            end
            2: begin
                exp_r = (cv << (W - 1)) | (av >> 1);
                tag = "R7";
            end
            default: begin
                exp_r = ((av << 1) & (M - 1)) | (1 - cv);
                tag = "R8";
            end
        endcase
        chk({tag, " result"}, int'(result), exp_r);
        if (src == 0) begin
            chk({tag, " carry_out"}, int'(carry_out), exp_c);
            chk("R5 overflow", int'(overflow), exp_v);
        end else begin
            chk("R9 flags", int'({carry_out, overflow}), 0);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset result", int'(result), 0);
        chk("R1 reset flags", int'({carry_out, overflow}), 0);
        rst = 1'b0;

        // Exhaustive sweep of operands, codes and carry
        for (int opv = 0; opv < 16; opv++)
            for (int av = 0; av < M; av++)
                for (int bv = 0; bv < M; bv++)
                    for (int cv = 0; cv < 2; cv++)
                        run_vec(av, bv, opv, cv);

        // Directed boundary cases
        run_vec(15, 15, 4'b0000, 1);   // R3 wrap with carry out
        run_vec(0, 0, 4'b0011, 0);     // R3 decrement of zero
        run_vec(7, 1, 4'b0000, 0);     // R5 positive overflow
        run_vec(8, 15, 4'b0000, 0);    // R5 negative overflow

        // R2: enable low holds outputs
        run_vec(7, 1, 4'b0000, 0);     // result 8, carry 0, overflow 1
        en = 1'b0;
        a = 4'h3; b = 4'h3; op = 4'b0100; carry_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 hold result", int'(result), 8);
        chk("R2 hold flags", int'({carry_out, overflow}), 1);

        // R10: no change before the edge, new value after it
        a = 4'h5; b = 4'h2; op = 4'b0000; carry_in = 1'b0; en = 1'b1;
        #1;
        chk("R10 before edge", int'(result), 8);
        @(posedge clk);
        @(negedge clk);
        chk("R10 after edge", int'(result), 7);

        // R1: mid-run reset
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid reset result", int'(result), 0);
        chk("R1 mid reset flags", int'({carry_out, overflow}), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule